// File: doc/BRIEF.md
# Pause Frame Receive Inhibitor

This block sits on the receive side of a full-duplex Ethernet MAC. It watches the received byte stream, finds flow-control PAUSE frames, and holds off the start of new data-frame transmissions for the time the frame asks for. The pause time is a 16-bit count of quanta. One quantum is one slot time, which is `QUANTUM_TICKS` pulses of the bit-time tick (512 by default). Every received byte, control frames included, is passed on unchanged one cycle later, so that later receive logic still sees the control frames.

A parser state machine walks each frame's header through the states PS_IDLE, PS_HDR, PS_PARAM, PS_TAIL and PS_SKIP. Any byte with the start strobe enters PS_HDR, or PS_SKIP if the first byte is wrong. A header byte that does not match its expected value sends PS_HDR to PS_SKIP. The last opcode byte moves PS_HDR to PS_PARAM. The second parameter byte moves PS_PARAM to PS_TAIL. The end strobe returns every state to PS_IDLE. A frame that ends in PS_TAIL with good status issues a load.

A gate state machine has the states GS_IDLE, GS_DEFER and GS_PAUSE. A load of zero sends any state to GS_IDLE. A nonzero load goes to GS_DEFER while the transmitter is busy, and to GS_PAUSE otherwise. GS_DEFER moves to GS_PAUSE when the transmitter goes idle, and the quantum timer starts there. GS_PAUSE returns to GS_IDLE when the timer expires. The transmit inhibit is high in GS_DEFER and GS_PAUSE.

Top module: `pause_rx_inhibit`

## Requirements
- R1: A frame is treated as PAUSE only if bytes 0..5 are 01 80 C2 00 00 01, bytes 12..13 are 88 08 and bytes 14..15 are 00 01. Bytes 6..11 (the source address) may hold any value. A wrong byte at any checked position leaves tx_inhibit unchanged.
- R2: The pause is taken only when the frame's last byte carries rx_eof together with rx_good=1. A frame that ends with rx_good=0, or that has fewer than 18 bytes, has no effect.
- R3: The pause parameter is bytes 16 (high) and 17 (low). With tx_busy low and bit_tick high on every cycle, tx_inhibit rises on the clock edge that samples the end byte. It then stays high for exactly parameter × QUANTUM_TICKS cycles.
- R4: The timer advances only on cycles with bit_tick=1. While bit_tick stays low, tx_inhibit stays high.
- R5: If a PAUSE frame ends while tx_busy=1, tx_inhibit goes high but the count does not start. Counting starts on the edge where tx_busy is first sampled low. From that edge, tx_inhibit stays high for parameter × QUANTUM_TICKS further cycles.
- R6: A new valid PAUSE frame replaces the running count. The inhibit then lasts parameter × QUANTUM_TICKS cycles from the new frame's end byte.
- R7: A valid PAUSE frame with parameter 0 drops tx_inhibit on the edge that samples its end byte, or leaves it low if it was already low.
- R8: Every input byte and its strobes appear on fwd_valid, fwd_data, fwd_sof, fwd_eof and fwd_good exactly one cycle later and unmodified. PAUSE frames are forwarded like any other frame.
- R9: After reset, tx_inhibit and fwd_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Received byte is valid this cycle |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | First byte of a frame (with rx_valid) |
| rx_eof | input | 1 | Last byte of a frame (with rx_valid) |
| rx_good | input | 1 | Frame status, sampled with rx_eof |
| tx_busy | input | 1 | Transmitter is sending a frame |
| bit_tick | input | 1 | One pulse per bit time |
| tx_inhibit | output | 1 | Hold off the start of new data frames |
| fwd_valid | output | 1 | Forwarded byte valid |
| fwd_data | output | 8 | Forwarded byte |
| fwd_sof | output | 1 | Forwarded start strobe |
| fwd_eof | output | 1 | Forwarded end strobe |
| fwd_good | output | 1 | Forwarded frame status |

## Verification
The assertions assume well-formed input framing. rx_sof, rx_eof and rx_good only have meaning while rx_valid is high. Every frame starts with a start strobe, and rx_good is only meaningful on the end byte. The bench drives frames one byte per cycle with the strobes only on the first and last bytes. It raises tx_busy and drops bit_tick only between frames or at points that are planned in advance. It sweeps pause parameters 1 to 24 and corrupts each checked header position in turn, using a small quantum so that every expected inhibit length is a plain product.

// File: rtl/pause_inh_pkg.sv
package pause_inh_pkg;

    localparam int PQ_W = 16;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_HDR,
        PS_PARAM,
        PS_TAIL,
        PS_SKIP
    } parse_st_t;

    typedef enum logic [1:0] {
        GS_IDLE,
        GS_DEFER,
        GS_PAUSE
    } gate_st_t;

    // Checks one header byte against the flow-control frame pattern.
    function automatic logic hdr_byte_ok(input logic [4:0] pos, input logic [7:0] b);
        logic ok;
        case (pos)
            5'd0:    ok = (b == 8'h01);
            5'd1:    ok = (b == 8'h80);
            5'd2:    ok = (b == 8'hC2);
            5'd3:    ok = (b == 8'h00);
            5'd4:    ok = (b == 8'h00);
            5'd5:    ok = (b == 8'h01);
            5'd12:   ok = (b == 8'h88);
            5'd13:   ok = (b == 8'h08);
            5'd14:   ok = (b == 8'h00);
            5'd15:   ok = (b == 8'h01);
            5'd6, 5'd7, 5'd8, 5'd9, 5'd10, 5'd11: ok = 1'b1;
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/pause_parser.sv
module pause_parser
    import pause_inh_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_valid,
    input  logic [7:0]      rx_data,
    input  logic            rx_sof,
    input  logic            rx_eof,
    input  logic            rx_good,
    output logic            pause_load,
    output logic [PQ_W-1:0] pause_val
);

    parse_st_t       state, nxt;
    logic [4:0]      pos, pos_n;
    logic [7:0]      hi_q, hi_n;
    logic [PQ_W-1:0] val_q, val_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PS_IDLE;
            pos   <= '0;
            hi_q  <= '0;
            val_q <= '0;
        end else begin
            state <= nxt;
            pos   <= pos_n;
            hi_q  <= hi_n;
            val_q <= val_n;
        end
    end

    always_comb begin
        nxt   = state;
        pos_n = pos;
        hi_n  = hi_q;
        val_n = val_q;
        if (rx_valid) begin
            if (rx_sof) begin
                pos_n = 5'd1;
                nxt   = hdr_byte_ok(5'd0, rx_data) ? PS_HDR : PS_SKIP;
            end else begin
                unique case (state)
                    PS_IDLE: nxt = PS_IDLE;
                    PS_HDR: begin
                        if (hdr_byte_ok(pos, rx_data)) begin
                            pos_n = pos + 5'd1;
                            if (pos == 5'd15) nxt = PS_PARAM;
                        end else begin
                            nxt = PS_SKIP;
                        end
                    end
                    PS_PARAM: begin
                        if (pos == 5'd16) begin
                            hi_n  = rx_data;
                            pos_n = 5'd17;
                        end else begin
                            val_n = {hi_q, rx_data};
                            nxt   = PS_TAIL;
                        end
                    end
                    PS_TAIL: nxt = PS_TAIL;
                    PS_SKIP: nxt = PS_SKIP;
                    default: nxt = PS_IDLE;
                endcase
            end
            if (rx_eof) nxt = PS_IDLE;
        end
    end

    // Output process: a load fires on a good end byte that completes the header.
    always_comb begin
        pause_load = 1'b0;
        pause_val  = val_q;
        if (rx_valid && rx_eof && rx_good && !rx_sof) begin
            if (state == PS_PARAM && pos == 5'd17) begin
                pause_load = 1'b1;
                pause_val  = {hi_q, rx_data};
            end else if (state == PS_TAIL) begin
                pause_load = 1'b1;
            end
        end
    end

    // R2: a load is only ever issued on a byte that ends a frame with good status
    p_load_on_good_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pause_load |-> (rx_valid && rx_eof && rx_good));

    // R1: after a load the parser is back at rest
    p_idle_after_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pause_load |=> (state == PS_IDLE));

endmodule

// File: rtl/pause_quanta_timer.sv
module pause_quanta_timer #(
    parameter int QUANTUM_TICKS = 512,
    parameter int CNT_W         = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] start_val,
    input  logic             run,
    input  logic             bit_tick,
    output logic             expire
);

    localparam int PW = (QUANTUM_TICKS > 1) ? $clog2(QUANTUM_TICKS) : 1;
    localparam logic [PW-1:0] LAST = PW'(QUANTUM_TICKS - 1);

    logic [PW-1:0]    presc;
    logic [CNT_W-1:0] quanta;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc  <= '0;
            quanta <= '0;
        end else if (start) begin
            presc  <= '0;
            quanta <= start_val;
        end else if (run && bit_tick) begin
            if (presc == LAST) begin
                presc  <= '0;
                quanta <= quanta - 1'b1;
            end else begin
                presc <= presc + 1'b1;
            end
        end
    end

    assign expire = run && bit_tick && !start && (presc == LAST) &&
                    (quanta == CNT_W'(1));

    // R4: without a tick the remaining count holds
    p_hold_without_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !bit_tick && !start) |=> $stable(quanta));

    // R3: the gate never runs the timer on an empty count
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (quanta != '0));

endmodule

// File: rtl/pause_gate.sv
module pause_gate
    import pause_inh_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [PQ_W-1:0] load_val,
    input  logic            tx_busy,
    input  logic            expire,
    output logic            start,
    output logic [PQ_W-1:0] start_val,
    output logic            running,
    output logic            tx_inhibit
);

    gate_st_t        state, nxt;
    logic [PQ_W-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= GS_IDLE;
            pend_q <= '0;
        end else begin
            state <= nxt;
            if (load) pend_q <= load_val;
        end
    end

    always_comb begin
        nxt = state;
        if (load) begin
            if (load_val == '0) nxt = GS_IDLE;
            else if (tx_busy)   nxt = GS_DEFER;
            else                nxt = GS_PAUSE;
        end else begin
            unique case (state)
                GS_IDLE:  nxt = GS_IDLE;
                GS_DEFER: if (!tx_busy) nxt = GS_PAUSE;
                GS_PAUSE: if (expire) nxt = GS_IDLE;
                default:  nxt = GS_IDLE;
            endcase
        end
    end

    // Output process
    always_comb begin
        start      = 1'b0;
        start_val  = pend_q;
        if (load) begin
            start_val = load_val;
            start     = (load_val != '0) && !tx_busy;
        end else if (state == GS_DEFER && !tx_busy) begin
            start = 1'b1;
        end
        running    = (state == GS_PAUSE);
        tx_inhibit = (state != GS_IDLE);
    end

    // R7: a zero parameter clears the inhibit on the next cycle
    p_zero_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val == '0) |=> !tx_inhibit);

    // R5: a pause arriving during a transmission inhibits but does not count
    p_busy_defers_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val != '0 && tx_busy) |=> (tx_inhibit && !running));

    // R5: counting never starts while the transmitter is still busy
    p_no_start_when_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !tx_busy);

endmodule

// File: rtl/pause_rx_inhibit.sv
module pause_rx_inhibit
    import pause_inh_pkg::*;
#(
    parameter int QUANTUM_TICKS = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_sof,
    input  logic       rx_eof,
    input  logic       rx_good,
    input  logic       tx_busy,
    input  logic       bit_tick,
    output logic       tx_inhibit,
    output logic       fwd_valid,
    output logic [7:0] fwd_data,
    output logic       fwd_sof,
    output logic       fwd_eof,
    output logic       fwd_good
);

    logic            pause_load;
    logic [PQ_W-1:0] pause_val;
    logic            t_start;
    logic [PQ_W-1:0] t_val;
    logic            t_run;
    logic            t_expire;

    pause_parser u_parser (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_sof     (rx_sof),
        .rx_eof     (rx_eof),
        .rx_good    (rx_good),
        .pause_load (pause_load),
        .pause_val  (pause_val)
    );

    pause_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (pause_load),
        .load_val   (pause_val),
        .tx_busy    (tx_busy),
        .expire     (t_expire),
        .start      (t_start),
        .start_val  (t_val),
        .running    (t_run),
        .tx_inhibit (tx_inhibit)
    );

    pause_quanta_timer #(
        .QUANTUM_TICKS (QUANTUM_TICKS),
        .CNT_W         (PQ_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (t_start),
        .start_val (t_val),
        .run       (t_run),
        .bit_tick  (bit_tick),
        .expire    (t_expire)
    );

    // Receive pass-through: control frames are forwarded, not dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid <= 1'b0;
            fwd_data  <= '0;
            fwd_sof   <= 1'b0;
            fwd_eof   <= 1'b0;
            fwd_good  <= 1'b0;
        end else begin
            fwd_valid <= rx_valid;
            fwd_data  <= rx_data;
            fwd_sof   <= rx_valid && rx_sof;
            fwd_eof   <= rx_valid && rx_eof;
            fwd_good  <= rx_valid && rx_good;
        end
    end

    // R8: each received byte shows up downstream one cycle later
    p_fwd_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> (fwd_valid && fwd_data == $past(rx_data)));

    // R3: once the count is done and nothing new arrives, the inhibit drops
    p_expire_releases_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (t_expire && !pause_load) |=> !tx_inhibit);

endmodule

// File: tb/pause_rx_inhibit_tb.sv
module pause_rx_inhibit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_valid, rx_sof, rx_eof, rx_good;
    logic [7:0] rx_data;
    logic       tx_busy, bit_tick;
    logic       tx_inhibit, fwd_valid, fwd_sof, fwd_eof, fwd_good;
    logic [7:0] fwd_data;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;
    logic [7:0] frm [0:63];

    always #(CLK_PERIOD/2) clk = ~clk;

    pause_rx_inhibit #(.QUANTUM_TICKS(Q)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_good(rx_good),
        .tx_busy(tx_busy), .bit_tick(bit_tick), .tx_inhibit(tx_inhibit),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data), .fwd_sof(fwd_sof),
        .fwd_eof(fwd_eof), .fwd_good(fwd_good)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic build(input int n, input int len);
        logic [7:0] hdr [0:15];
        hdr = '{8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h01,
                8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55,
                8'h88, 8'h08, 8'h00, 8'h01};
        for (int i = 0; i < 64; i++) frm[i] = 8'h00;
        for (int i = 0; i < 16; i++) frm[i] = hdr[i];
        frm[16] = n[15:8];
        frm[17] = n[7:0];
        if (len > 18) for (int i = 18; i < len; i++) frm[i] = 8'(i * 7);
    endtask

    // Sends frm[0..len-1]; returns at the negedge after the end byte's edge.
    task automatic send(input int len, input bit good);
        int fbad = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i > 0 && !(fwd_valid && fwd_data == frm[i-1] && fwd_sof == (i == 1)))
                fbad++;
            rx_valid = 1'b1;
            rx_data  = frm[i];
            rx_sof   = (i == 0);
            rx_eof   = (i == len - 1);
            rx_good  = (i == len - 1) ? good : 1'b0;
        end
        @(negedge clk);
        if (!(fwd_valid && fwd_data == frm[len-1] && fwd_eof && fwd_good == good))
            fbad++;
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_good = 1'b0;
        chk(fbad == 0, "R8 forwarded bytes", fbad, 0);
    endtask

    task automatic measure(input int limit, output int n);
        n = 0;
        while (tx_inhibit && n < limit) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int m;
        rst_n = 1'b0; rx_valid = 1'b0; rx_data = '0; rx_sof = 1'b0;
        rx_eof = 1'b0; rx_good = 1'b0; tx_busy = 1'b0; bit_tick = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_inhibit == 1'b0, "R9 inhibit after reset", tx_inhibit, 0);
        chk(fwd_valid == 1'b0, "R9 fwd_valid after reset", fwd_valid, 0);

        // R3 sweep of parameters; R1 positive match
        for (int n = 1; n <= 24; n++) begin
            build(n, (n % 2) ? 18 : 64);
            send((n % 2) ? 18 : 64, 1'b1);
            measure(1000, m);
            chk(m == n * Q, "R3 pause length", m, n * Q);
        end

        // R7 zero parameter when idle
        build(0, 18); send(18, 1'b1); measure(50, m);
        chk(m == 0, "R7 zero when idle", m, 0);

        // R1 corrupt each checked header position
        for (int p = 0; p < 16; p++) begin
            if (p < 6 || p > 11) begin
                build(5, 20);
                frm[p] = frm[p] ^ 8'h01;
                send(20, 1'b1);
                measure(60, m);
                chk(m == 0, "R1 corrupt header byte", m, 0);
            end
        end
        // R1 source address is ignored
        build(2, 18); frm[8] = 8'hFF; send(18, 1'b1); measure(100, m);
        chk(m == 2 * Q, "R1 any source address", m, 2 * Q);

        // R2 bad status and short frame
        build(6, 18); send(18, 1'b0); measure(60, m);
        chk(m == 0, "R2 bad status ignored", m, 0);
        build(6, 17); send(17, 1'b1); measure(60, m);
        chk(m == 0, "R2 short frame ignored", m, 0);

        // R4 no ticks
        bit_tick = 1'b0;
        build(2, 18); send(18, 1'b1);
        repeat (100) @(negedge clk);
        chk(tx_inhibit == 1'b1, "R4 holds without tick", tx_inhibit, 1);
        bit_tick = 1'b1;
        measure(100, m);
        chk(m == 2 * Q, "R4 resumes with tick", m, 2 * Q);

        // R5 deferral during transmission
        tx_busy = 1'b1;
        build(3, 18); send(18, 1'b1);
        chk(tx_inhibit == 1'b1, "R5 inhibit during busy", tx_inhibit, 1);
        repeat (40) @(negedge clk);
        chk(tx_inhibit == 1'b1, "R5 no count while busy", tx_inhibit, 1);
        tx_busy = 1'b0;
        measure(100, m);
        chk(m == 3 * Q + 1, "R5 count after busy", m, 3 * Q + 1);

        // R6 overwrite
        build(20, 18); send(18, 1'b1);
        repeat (5) @(negedge clk);
        build(3, 18); send(18, 1'b1);
        measure(200, m);
        chk(m == 3 * Q, "R6 overwrite", m, 3 * Q);

        // R7 zero clears a running pause
        build(20, 18); send(18, 1'b1);
        repeat (5) @(negedge clk);
        build(0, 18); send(18, 1'b1);
        chk(tx_inhibit == 1'b0, "R7 zero clears", tx_inhibit, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule